// File: doc/BRIEF.md
# Fixed-Point Neuron Reaction Pipeline

This block applies the per-cell reaction update of a two-variable excitable neuron model, one neuron per clock. A cell arrives as a state word carrying the activation value `r` and two flag bits (target, frozen), together with its recovery value `v` and an activation threshold. Two pipelines run side by side. The recovery pipeline produces the next `v` after four stages. The activation pipeline evaluates a cubic nonlinearity by Horner's rule in six stages, gates the result with a step function of `r` against the threshold, removes a decay term where the target flag is set, and holds `r` unchanged where the frozen flag is set. It produces the next `r` word after nine stages.

All values are signed fixed point with 20 fraction bits in 24 bits (range -8.0 to just under +8.0). The time step is 0.1, folded into constant coefficients. Inputs form one valid/ready stream. The two results leave as two output strobes that share a single ready. `out_ready` low freezes every stage, so both output registers keep their values. `in_ready` mirrors `out_ready`, so an input transfer happens exactly when `in_valid` and `out_ready` are both high. The `v` result of a cell appears five advancing cycles before its `r` result, which lets a consumer stagger the two write enables.

Top module: `nrx_neuron_react`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `v_valid` and `r_valid` are 0.
- R2: Recovery output: `v_out = sat(v + mul(sat(r - 7v - 2.0), KV))`, where KV is the raw value 4194 (0.1/25). It appears on `v_valid` after 4 advancing clock edges.
- R3: Activation output: f(r) is computed by Horner steps `y = add(mul(y, r), c)`. It starts from c3 = -149797 and then uses c2 = 599186, c1 = -299593 and c0 = -299593 (raw). Then `r_out[23:0] = sub(add(r, mul(g, KH)), t)`, where KH = 104858 (0.1). The result appears on `r_valid` after 9 advancing clock edges.
- R4: The gate g equals `sub(f, v)` when r is below the threshold (signed compare), and 0 otherwise.
- R5: The target flag is bit 24 of the word. When it is set, t = `mul(r, KH)`; when it is clear, t = 0.
- R6: The frozen flag is bit 25. When it is set, `r_out[23:0]` equals the input r. Bits 27:24 always pass through unchanged.
- R7: `mul(a,b)` rounds `(a*b + 2^19) >>> 20` and saturates. Every add and subtract saturates, and `sat` clamps to the range [-2^23, 2^23-1].
- R8: While `out_ready` is low, `in_ready` is low and `v_out`, `r_out`, `v_valid` and `r_valid` hold their values.
- R9: Results leave in input order. A cell's `v` result is never later than its `r` result, and no result appears without an accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input cell valid |
| in_ready | output | 1 | Input accepted when high with in_valid |
| in_word | input | 28 | r in [23:0], target [24], frozen [25], spare [27:26] |
| in_v | input | 24 | Recovery value of the cell |
| thr | input | 24 | Activation threshold, sampled with the cell |
| out_ready | input | 1 | Consumer ready, shared by both outputs |
| v_valid | output | 1 | v_out holds a result |
| v_out | output | 24 | Updated recovery value |
| r_valid | output | 1 | r_out holds a result |
| r_out | output | 28 | Updated state word |

## Verification
A wrong coefficient, rounding step or saturation bound shows as a mismatch in `v_out` or `r_out` on the first cell whose operands reach it. That happens within 4 or 9 advancing cycles of acceptance, and the random operand spread and the rail-to-rail corners make such a cell arrive early. A stage that drops or repeats a cell shifts every later result, so the next comparison in the ordered check fails. A stage that ignores the stall changes an output while `out_ready` is low, which the hold checks catch within one cycle. A flag bit taken from the wrong position changes `r_out` on the first target or frozen cell.

// File: rtl/nrx_pkg.sv
package nrx_pkg;
  localparam int QW          = 24;
  localparam int QF          = 20;
  localparam int WW          = 2 * QW;
  localparam int FLAGW       = 4;
  localparam int WORDW       = QW + FLAGW;
  localparam int T_POS       = 0;      // bit QW+0 of the word
  localparam int Q_POS       = 1;      // bit QW+1 of the word
  localparam int CUBIC_ORDER = 3;
  localparam int HSTG        = 2 * CUBIC_ORDER;
  localparam int LAT_V       = 4;
  localparam int LAT_R       = HSTG + 3;

  typedef logic signed [QW-1:0] q_t;
  typedef logic signed [WW-1:0] w_t;

  typedef struct packed {
    logic             vld;
    logic             h;
    logic [FLAGW-1:0] flags;
    q_t               r;
    q_t               v;
  } side_t;

  localparam w_t W_MAX = (w_t'(1) <<< (QW - 1)) - w_t'(1);
  localparam w_t W_MIN = -(w_t'(1) <<< (QW - 1));

  localparam q_t K_H   = q_t'(((1 << QF) + 5) / 10);
  localparam q_t K_V   = q_t'(((1 << QF) + 125) / 250);
  localparam q_t K_TWO = q_t'(2 << QF);
  localparam q_t C3    = q_t'(-(((1 << QF) + 3) / 7));
  localparam q_t C2    = q_t'(((4 << QF) + 3) / 7);
  localparam q_t C1    = q_t'(-(((2 << QF) + 3) / 7));
  localparam q_t C0    = q_t'(-(((2 << QF) + 3) / 7));

  function automatic q_t q_sat(input w_t x);
    if (x > W_MAX)      return q_t'(W_MAX);
    else if (x < W_MIN) return q_t'(W_MIN);
    else                return q_t'(x);
  endfunction

  function automatic q_t q_mul(input q_t a, input q_t b);
    w_t wa, wb, p;
    wa = a;
    wb = b;
    p  = wa * wb + (w_t'(1) <<< (QF - 1));
    return q_sat(p >>> QF);
  endfunction

  function automatic q_t q_add(input q_t a, input q_t b);
    w_t wa, wb;
    wa = a;
    wb = b;
    return q_sat(wa + wb);
  endfunction

  function automatic q_t q_sub(input q_t a, input q_t b);
    w_t wa, wb;
    wa = a;
    wb = b;
    return q_sat(wa - wb);
  endfunction
endpackage

// File: rtl/nrx_recovery.sv
module nrx_recovery import nrx_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic in_vld,
  input  q_t   r_in,
  input  q_t   v_in,
  output logic out_vld,
  output q_t   v_out
);
  q_t   d1, v1, p2, v2, s3;
  logic vl1, vl2, vl3;
  w_t   lin;

  always_comb begin
    lin = w_t'(r_in) - 7 * w_t'(v_in) - w_t'(K_TWO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= '0; v1 <= '0; vl1 <= 1'b0;
      p2 <= '0; v2 <= '0; vl2 <= 1'b0;
      s3 <= '0; vl3 <= 1'b0;
      v_out <= '0; out_vld <= 1'b0;
    end else if (adv) begin
      d1  <= q_sat(lin);
      v1  <= v_in;
      vl1 <= in_vld;
      p2  <= q_mul(d1, K_V);
      v2  <= v1;
      vl2 <= vl1;
      s3  <= q_add(v2, p2);
      vl3 <= vl2;
      v_out   <= s3;
      out_vld <= vl3;
    end
  end

  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(v_out) && $stable(out_vld)))
    else $error("v output moved during stall"); // R8
endmodule

// File: rtl/nrx_horner.sv
module nrx_horner import nrx_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  q_t   x_in,
  output q_t   f_out
);
  localparam int XD = 2 * (CUBIC_ORDER - 1);
  localparam q_t COEF [0:CUBIC_ORDER] = '{C3, C2, C1, C0};

  q_t xd   [0:XD];
  q_t acc  [0:CUBIC_ORDER];
  q_t prod [0:CUBIC_ORDER-1];

  assign xd[0]  = x_in;
  assign acc[0] = COEF[0];

  for (genvar j = 1; j <= XD; j++) begin : g_xdly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   xd[j] <= '0;
      else if (adv) xd[j] <= xd[j-1];
    end
  end

  for (genvar k = 0; k < CUBIC_ORDER; k++) begin : g_step
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod[k]  <= '0;
        acc[k+1] <= '0;
      end else if (adv) begin
        prod[k]  <= q_mul(acc[k], xd[2*k]);
        acc[k+1] <= q_add(prod[k], COEF[k+1]);
      end
    end
  end

  assign f_out = acc[CUBIC_ORDER];
endmodule

// File: rtl/nrx_activation.sv
module nrx_activation import nrx_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             in_vld,
  input  logic [WORDW-1:0] in_word,
  input  q_t               in_v,
  input  q_t               thr,
  output logic             out_vld,
  output logic [WORDW-1:0] out_word
);
  side_t sb [0:HSTG];
  q_t    f6, g7, t7, r7, a8, t8, r8;
  logic [FLAGW-1:0] fl7, fl8;
  logic  vl7, vl8;
  q_t    r0;

  assign r0 = in_word[QW-1:0];
  assign sb[0] = '{vld: in_vld, h: (r0 < thr), flags: in_word[WORDW-1:QW],
                   r: r0, v: in_v};

  for (genvar i = 1; i <= HSTG; i++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sb[i] <= '0;
      else if (adv) sb[i] <= sb[i-1];
    end
  end

  nrx_horner u_cubic (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .x_in  (r0),
    .f_out (f6)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g7 <= '0; t7 <= '0; r7 <= '0; fl7 <= '0; vl7 <= 1'b0;
      a8 <= '0; t8 <= '0; r8 <= '0; fl8 <= '0; vl8 <= 1'b0;
      out_word <= '0; out_vld <= 1'b0;
    end else if (adv) begin
      g7  <= sb[HSTG].h ? q_sub(f6, sb[HSTG].v) : '0;
      t7  <= sb[HSTG].flags[T_POS] ? q_mul(sb[HSTG].r, K_H) : '0;
      r7  <= sb[HSTG].r;
      fl7 <= sb[HSTG].flags;
      vl7 <= sb[HSTG].vld;
      a8  <= q_mul(g7, K_H);
      t8  <= t7;
      r8  <= r7;
      fl8 <= fl7;
      vl8 <= vl7;
      out_word <= {fl8, fl8[Q_POS] ? r8 : q_sub(q_add(r8, a8), t8)};
      out_vld  <= vl8;
    end
  end

  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(out_word) && $stable(out_vld)))
    else $error("r output moved during stall"); // R8
endmodule

// File: rtl/nrx_neuron_react.sv
module nrx_neuron_react import nrx_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WORDW-1:0] in_word,
  input  logic [QW-1:0]    in_v,
  input  logic [QW-1:0]    thr,
  input  logic             out_ready,
  output logic             v_valid,
  output logic [QW-1:0]    v_out,
  output logic             r_valid,
  output logic [WORDW-1:0] r_out
);
  localparam int CW = $clog2(LAT_R + 2);

  logic adv, acc, vdone, rdone;
  q_t   v_res;
  logic [CW-1:0] infl_v, infl_r;

  assign adv      = out_ready;
  assign in_ready = out_ready;
  assign acc      = in_valid && out_ready;
  assign vdone    = v_valid && out_ready;
  assign rdone    = r_valid && out_ready;

  nrx_recovery u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .in_vld  (in_valid),
    .r_in    (q_t'(in_word[QW-1:0])),
    .v_in    (q_t'(in_v)),
    .out_vld (v_valid),
    .v_out   (v_res)
  );
  assign v_out = v_res;

  nrx_activation u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .in_vld   (in_valid),
    .in_word  (in_word),
    .in_v     (q_t'(in_v)),
    .thr      (q_t'(thr)),
    .out_vld  (r_valid),
    .out_word (r_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      infl_v <= '0;
      infl_r <= '0;
    end else begin
      infl_v <= infl_v + CW'(acc) - CW'(vdone);
      infl_r <= infl_r + CW'(acc) - CW'(rdone);
    end
  end

  AST_V_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    infl_v <= CW'(LAT_V)) else $error("too many v in flight"); // R2
  AST_R_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    infl_r <= CW'(LAT_R)) else $error("too many r in flight"); // R3
  AST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    infl_r >= infl_v) else $error("r result ahead of v result"); // R9
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (infl_v == '0) |-> !v_valid) else $error("v result without input"); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!v_valid && !r_valid)) else $error("valid after reset"); // R1
endmodule

// File: tb/nrx_neuron_react_test.sv
module nrx_neuron_react_test;
  localparam int CLK_PERIOD = 10;
  typedef logic signed [47:0] mw_t;
  typedef logic signed [23:0] mq_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [27:0] in_word = '0;
  logic [23:0] in_v = '0;
  logic [23:0] thr = '0;
  logic        out_ready = 1'b0;
  logic        v_valid, r_valid;
  logic [23:0] v_out;
  logic [27:0] r_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit obs_vv, obs_rv;

  logic [23:0] qv[$];
  logic [27:0] qr[$];
  int          qt[$];

  nrx_neuron_react uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_v(in_v), .thr(thr), .out_ready(out_ready),
    .v_valid(v_valid), .v_out(v_out), .r_valid(r_valid), .r_out(r_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic mq_t m_sat(input mw_t x);
    mw_t hi, lo;
    hi = 48'sd8388607;
    lo = -48'sd8388608;
    if (x > hi) return 24'sh7FFFFF;
    if (x < lo) return 24'sh800000;
    return mq_t'(x);
  endfunction

  function automatic mq_t m_mul(input mq_t a, input mq_t b);
    mw_t wa, wb;
    wa = a;
    wb = b;
    return m_sat((wa * wb + 48'sd524288) >>> 20);
  endfunction

  function automatic mq_t m_add(input mq_t a, input mq_t b);
    mw_t wa, wb;
    wa = a;
    wb = b;
    return m_sat(wa + wb);
  endfunction

  function automatic mq_t m_sub(input mq_t a, input mq_t b);
    mw_t wa, wb;
    wa = a;
    wb = b;
    return m_sat(wa - wb);
  endfunction

  // R2 model
  function automatic logic [23:0] exp_v(input mq_t r, input mq_t v);
    mw_t wr, wv;
    mq_t d;
    wr = r;
    wv = v;
    d = m_sat(wr - 7 * wv - 48'sd2097152);
    return m_add(v, m_mul(d, 24'sd4194));
  endfunction

  // R3..R6 model
  function automatic logic [27:0] exp_r(input logic [27:0] w, input mq_t v, input mq_t th);
    mq_t r, y, g, t, res;
    r = w[23:0];
    y = -24'sd149797;
    y = m_add(m_mul(y, r), 24'sd599186);
    y = m_add(m_mul(y, r), -24'sd299593);
    y = m_add(m_mul(y, r), -24'sd299593);
    g = (r < th) ? m_sub(y, v) : 24'sd0;
    t = w[24] ? m_mul(r, 24'sd104858) : 24'sd0;
    res = w[25] ? r : m_sub(m_add(r, m_mul(g, 24'sd104858)), t);
    return {w[27:24], res};
  endfunction

  function automatic string tname(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic cycle(input bit iv, input logic [27:0] w, input mq_t v, input mq_t th,
                       input bit rdy, input int tag);
    logic [23:0] ev;
    logic [27:0] er;
    int tg;
    @(negedge clk);
    in_valid = iv; in_word = w; in_v = v; thr = th; out_ready = rdy;
    #1;
    obs_vv = v_valid;
    obs_rv = r_valid;
    if (v_valid && rdy) begin
      if (qv.size() == 0) check(1'b0, "R9", 32'(v_out), 32'hx);
      else begin
        ev = qv.pop_front();
        check(v_out == ev, "R2", 32'(v_out), 32'(ev));
      end
    end
    if (r_valid && rdy) begin
      if (qr.size() == 0) check(1'b0, "R9", 32'(r_out), 32'hx);
      else begin
        er = qr.pop_front();
        tg = qt.pop_front();
        check(r_out == er, tname(tg), 32'(r_out), 32'(er));
      end
    end
    if (iv && in_ready) begin
      qv.push_back(exp_v(mq_t'(w[23:0]), v));
      qr.push_back(exp_r(w, v, th));
      if (tag != 0)   tg = tag;
      else if (w[25]) tg = 6;
      else if (w[24]) tg = 5;
      else if ($signed(w[23:0]) < th) tg = 4;
      else tg = 3;
      qt.push_back(tg);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [27:0] snap_r;
    logic [23:0] snap_v;
    void'($urandom(32'd20240611));

    // R1: reset quiet, ready mirrors out_ready
    repeat (3) @(negedge clk);
    check(!v_valid && !r_valid, "R1", {30'd0, v_valid, r_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b0;
    #1;
    check(in_ready == 1'b0, "R8", 32'(in_ready), 32'd0);
    check(!v_valid && !r_valid, "R1", {30'd0, v_valid, r_valid}, 32'd0);
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R1", 32'(in_ready), 32'd1);

    // R2 / R3 latency: one cell, count edges
    cycle(1'b1, 28'h0080000, 24'sh040000, 24'sh100000, 1'b1, 4);
    for (int k = 1; k <= 10; k++) begin
      cycle(1'b0, '0, '0, '0, 1'b1, 0);
      check(obs_vv == (k == 4), "R2", 32'(obs_vv), 32'(k == 4));
      check(obs_rv == (k == 9), "R3", 32'(obs_rv), 32'(k == 9));
    end

    // directed corners
    cycle(1'b1, 28'h0080000, 24'sh000000, 24'sh100000, 1'b1, 4);  // R4 gate on
    cycle(1'b1, 28'h0200000, 24'sh080000, 24'sh100000, 1'b1, 3);  // R3 gate off
    cycle(1'b1, 28'h1100000, 24'sh020000, 24'sh000000, 1'b1, 5);  // R5 target
    cycle(1'b1, 28'h1080000, 24'sh020000, 24'sh100000, 1'b1, 5);  // R5 target, gate on
    cycle(1'b1, 28'hEE80000, 24'sh300000, 24'sh7FFFFF, 1'b1, 6);  // R6 frozen, spare bits
    cycle(1'b1, 28'h27FFFFF, 24'sh800000, 24'sh7FFFFF, 1'b1, 6);  // R6 frozen at rail
    cycle(1'b1, 28'h07FFFFF, 24'sh800000, 24'sh7FFFFF, 1'b1, 7);  // R7 saturation high
    cycle(1'b1, 28'h0800000, 24'sh7FFFFF, 24'sh000000, 1'b1, 7);  // R7 saturation low
    cycle(1'b1, 28'h0800000, 24'sh7FFFFF, 24'sh7FFFFF, 1'b1, 7);  // R7 low with gate
    cycle(1'b1, 28'hC000001, 24'sh800000, 24'sh000002, 1'b1, 7);  // R7 rounding near zero
    for (int k = 0; k < 12; k++) cycle(1'b0, '0, '0, '0, 1'b1, 0);

    // R8: stall holds outputs
    for (int k = 0; k < 12; k++)
      cycle(1'b1, 28'($urandom), mq_t'($urandom), mq_t'($urandom), 1'b1, 0);
    cycle(1'b1, 28'h0100000, 24'sh0, 24'sh0, 1'b0, 0);
    snap_r = r_out;
    snap_v = v_out;
    for (int k = 0; k < 3; k++) begin
      cycle(1'b1, 28'h0100000, 24'sh0, 24'sh0, 1'b0, 0);
      check(r_out == snap_r && obs_rv, "R8", 32'(r_out), 32'(snap_r));
      check(v_out == snap_v && obs_vv, "R8", 32'(v_out), 32'(snap_v));
      check(in_ready == 1'b0, "R8", 32'(in_ready), 32'd0);
    end

    // random mix with back-pressure, R9 ordering through the queues
    for (int n = 0; n < 3000; n++) begin
      logic [27:0] w;
      mq_t vv, th;
      w  = 28'($urandom);
      w[23:0] = 24'($signed(w[23:0]) >>> ($urandom % 3));
      vv = mq_t'($signed(24'($urandom)) >>> ($urandom % 3));
      th = mq_t'($signed(24'($urandom)) >>> 1);
      cycle(($urandom % 5) != 0, w, vv, th, ($urandom % 10) < 7, 0);
    end

    for (int k = 0; k < 40; k++) cycle(1'b0, '0, '0, '0, 1'b1, 0);
    check(qv.size() == 0, "R9", 32'(qv.size()), 32'd0);
    check(qr.size() == 0, "R9", 32'(qr.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule